// File: doc/BRIEF.md
# Chained Two-Dimensional Word-Copy Engine

This engine copies 32-bit words between memory locations. The work for each copy comes from a descriptor of six consecutive words held in memory. A start pulse loads the head pointer. The engine then fetches descriptors one after another and moves their data through a single-outstanding request/acknowledge memory port. After each descriptor it follows that descriptor's link word. It continues while the channel enable input is high and the link is non-zero.

A descriptor is either linear or two-dimensional. A linear descriptor has one row whose byte count is the whole length word. A two-dimensional descriptor packs a row count and a per-row byte count into the length word. Between rows it adds signed 16-bit strides to the source and destination addresses. Flags in the info word can suppress the source read (the data is then zero), suppress the destination write, or hold either address fixed. The live descriptor fields are visible on outputs throughout, and the length field counts down after every word. When a descriptor ends, the engine gives a one-cycle done pulse together with the descriptor's interrupt-request bit.

Top module: `desc_dma2d`

## Requirements
- R1: After reset `idle_o` is 1 and `mem_req`, `done_o` and `irq_o` are 0. While idle, no memory request is made.
- R2: On `start` while idle, if `chan_en` is 1 and the pointer is non-zero, the engine reads six words at pointer+0, +4, +8, +12, +16 and +20. These words load, in that order, `info_o`, `src_o`, `dst_o`, `len_o`, `stride_o` and `next_o`.
- R3: After each descriptor the pointer takes the value of `next_o`. Processing continues while `chan_en` is 1 and the pointer is non-zero, and otherwise the engine returns to idle. `chan_en` is sampled only between descriptors, so a descriptor that has started always completes. A `start` pulse while busy is ignored.
- R4: When info bit 1 is 0 (linear mode), the descriptor moves length/4 words. Byte counts are multiples of 4.
- R5: When info bit 1 is 1 (2D mode), the row count is length[29:16] and the bytes per row are length[15:0]. The byte count is reloaded at the start of every row.
- R6: In 2D mode, the signed stride[15:0] is added to the source address and the signed stride[31:16] to the destination address between rows, but not after the last row.
- R7: When info bit 11 is 1, no source read is issued and the word written is 0.
- R8: When info bit 7 is 1, no destination write is issued.
- R9: Info bit 8 adds 4 to the source address after each word. Info bit 4 does the same for the destination address. When a bit is clear, that address stays fixed within a row.
- R10: After each word the row byte count drops by 4. `len_o` then becomes {2'b0, remaining rows[13:0], bytes[15:0]} in 2D mode, or the remaining bytes in linear mode.
- R11: At the end of each descriptor, `done_o` is high for exactly one cycle and `irq_o` equals info bit 0 during that cycle. At that point the live fields hold their final values.
- R12: A memory request holds its address, write flag and write data stable until `mem_ack`. Only one request is outstanding at a time.
- R13: A 2D descriptor with zero rows, or any row with zero bytes, moves no data but still completes with a done pulse. Strides are still applied between empty rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin walking the list at `head_ptr` (ignored while busy) |
| chan_en | input | 1 | Channel enable, sampled between descriptors |
| head_ptr | input | 32 | Address of the first descriptor |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes on this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| info_o | output | 32 | Live info word |
| src_o | output | 32 | Live source address |
| dst_o | output | 32 | Live destination address |
| len_o | output | 32 | Live remaining length |
| stride_o | output | 32 | Stride word |
| next_o | output | 32 | Link to the next descriptor |
| cur_o | output | 32 | Current descriptor pointer |
| done_o | output | 1 | One-cycle pulse when a descriptor ends |
| irq_o | output | 1 | Interrupt request of the ending descriptor |
| idle_o | output | 1 | Engine is idle |

## Verification
The assertions check these properties on every cycle:
- Request stability during a handshake.
- The single-cycle shape of the done pulse.
- The tie between `irq_o` and `done_o`.
- The absence of writes when the write-suppress flag is set.
- Silence on the memory port while idle.

Only the bench scenarios can show the rest. These are the address order of fetches and data reads, and the data written. They also include stride arithmetic with negative values, the live length countdown, empty rows and zero-row descriptors. Finally, they cover an enable drop in the middle of a descriptor and a start pulse that arrives while busy. The bench checks these against a behavioural model of the whole descriptor walk.

// File: rtl/desc_dma2d.sv
module desc_dma2d (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        chan_en,
  input  logic [31:0] head_ptr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic [31:0] info_o,
  output logic [31:0] src_o,
  output logic [31:0] dst_o,
  output logic [31:0] len_o,
  output logic [31:0] stride_o,
  output logic [31:0] next_o,
  output logic [31:0] cur_o,
  output logic        done_o,
  output logic        irq_o,
  output logic        idle_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_FETCH, S_SETUP, S_XRD, S_XWR, S_ROWEND, S_DONE
  } state_t;

  state_t      state;
  logic [2:0]  idx;
  logic [31:0] cur, info, src, dst, len, strd, nxt;
  logic [13:0] rows;
  logic [31:0] row_len, bytes, data;

  logic        two_d, rd_phase, wr_phase, word_done;
  logic [13:0] rows_init;
  logic [31:0] row_len_init, bytes_nx, sstep, dstep;

  assign two_d        = info[1];
  assign rd_phase     = (state == S_XRD) && !info[11];
  assign wr_phase     = (state == S_XWR) && !info[7];
  assign word_done    = (state == S_XWR) && (info[7] || mem_ack);
  assign rows_init    = two_d ? len[29:16] : 14'd1;
  assign row_len_init = two_d ? {16'd0, len[15:0]} : len;
  assign bytes_nx     = bytes - 32'd4;
  assign sstep        = {{16{strd[15]}}, strd[15:0]};
  assign dstep        = {{16{strd[31]}}, strd[31:16]};

  assign mem_req   = (state == S_FETCH) || rd_phase || wr_phase;
  assign mem_we    = wr_phase;
  assign mem_addr  = (state == S_FETCH) ? cur + {27'd0, idx, 2'd0} :
                     (wr_phase ? dst : src);
  assign mem_wdata = data;

  assign info_o   = info;
  assign src_o    = src;
  assign dst_o    = dst;
  assign len_o    = len;
  assign stride_o = strd;
  assign next_o   = nxt;
  assign cur_o    = cur;
  assign done_o   = (state == S_DONE);
  assign irq_o    = (state == S_DONE) && info[0];
  assign idle_o   = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      cur     <= '0;
      info    <= '0;
      src     <= '0;
      dst     <= '0;
      len     <= '0;
      strd    <= '0;
      nxt     <= '0;
      rows    <= '0;
      row_len <= '0;
      bytes   <= '0;
      data    <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            cur   <= head_ptr;
            state <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (chan_en && cur != 32'd0) begin
            idx   <= '0;
            state <= S_FETCH;
          end else begin
            state <= S_IDLE;
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            case (idx)
              3'd0:    info <= mem_rdata;
              3'd1:    src  <= mem_rdata;
              3'd2:    dst  <= mem_rdata;
              3'd3:    len  <= mem_rdata;
              3'd4:    strd <= mem_rdata;
              default: nxt  <= mem_rdata;
            endcase
            if (idx == 3'd5) state <= S_SETUP;
            else             idx   <= idx + 3'd1;
          end
        end
        S_SETUP: begin
          rows    <= rows_init;
          row_len <= row_len_init;
          bytes   <= row_len_init;
          if (rows_init == 14'd0)         state <= S_DONE;
          else if (row_len_init == 32'd0) state <= S_ROWEND;
          else                            state <= S_XRD;
        end
        S_XRD: begin
          if (info[11]) begin
            data  <= 32'd0;
            state <= S_XWR;
          end else if (mem_ack) begin
            data  <= mem_rdata;
            state <= S_XWR;
          end
        end
        S_XWR: begin
          if (word_done) begin
            if (info[8]) src <= src + 32'd4;
            if (info[4]) dst <= dst + 32'd4;
            bytes <= bytes_nx;
            len   <= two_d ? {2'b00, rows, bytes_nx[15:0]} : bytes_nx;
            state <= (bytes_nx == 32'd0) ? S_ROWEND : S_XRD;
          end
        end
        S_ROWEND: begin
          rows <= rows - 14'd1;
          if (rows != 14'd1) begin
            src   <= src + sstep;
            dst   <= dst + dstep;
            bytes <= row_len;
            state <= (row_len == 32'd0) ? S_ROWEND : S_XRD;
          end else begin
            state <= S_DONE;
          end
        end
        S_DONE: begin
          cur   <= nxt;
          state <= S_CHECK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/desc_dma2d_chk.sv
module desc_dma2d_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] info_o,
  input logic        done_o,
  input logic        irq_o,
  input logic        idle_o
);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done_o);

  // R8
  no_skipped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !info_o[7]);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !mem_req && !done_o);

  // R3
  done_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !idle_o);

endmodule

bind desc_dma2d desc_dma2d_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .info_o(info_o), .done_o(done_o), .irq_o(irq_o), .idle_o(idle_o)
);

// File: tb/desc_dma2d_tb_top.sv
`timescale 1ns/1ps
module desc_dma2d_tb_top;

  logic        clk = 0, rst_n = 0, start = 0, chan_en = 1;
  logic [31:0] head_ptr = 0;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [31:0] info_o, src_o, dst_o, len_o, stride_o, next_o, cur_o;
  logic        done_o, irq_o, idle_o;

  always #2 clk = ~clk;

  desc_dma2d dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_en(chan_en), .head_ptr(head_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .info_o(info_o), .src_o(src_o), .dst_o(dst_o), .len_o(len_o),
    .stride_o(stride_o), .next_o(next_o), .cur_o(cur_o),
    .done_o(done_o), .irq_o(irq_o), .idle_o(idle_o)
  );

  typedef struct packed {
    logic [31:0] addr, data, len;
  } wr_t;
  typedef struct packed {
    logic        irq;
    logic [31:0] info, src, dst, len, nxt;
  } dn_t;

  logic [31:0] mem [0:1023];
  logic [31:0] mm  [0:1023];
  wr_t         exp_wr[$];
  dn_t         exp_dn[$];
  logic [31:0] exp_rd[$];
  int tests = 0, fails = 0, cyc = 0, cnt = 0, lat = 0;
  bit finished = 0;

  function automatic int widx(logic [31:0] a);
    return int'(a[11:2]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] inf, s, d, l, st, n);
    mem[widx(a)]     = inf;
    mem[widx(a) + 1] = s;
    mem[widx(a) + 2] = d;
    mem[widx(a) + 3] = l;
    mem[widx(a) + 4] = st;
    mem[widx(a) + 5] = n;
  endtask

  task automatic model_run(input logic [31:0] head, input int max_desc);
    logic [31:0] ptr, inf, s, d, l, st, b, rb, dat;
    logic signed [31:0] ss, ds;
    int rows, n;
    for (int i = 0; i < 1024; i++) mm[i] = mem[i];
    exp_wr.delete(); exp_dn.delete(); exp_rd.delete();
    ptr = head; n = 0;
    while (ptr != 0 && n < max_desc) begin
      for (int k = 0; k < 6; k++) exp_rd.push_back(ptr + 32'(4 * k));
      inf = mm[widx(ptr)];     s  = mm[widx(ptr) + 1];
      d   = mm[widx(ptr) + 2]; l  = mm[widx(ptr) + 3];
      st  = mm[widx(ptr) + 4];
      if (inf[1]) begin
        rows = int'(l[29:16]); rb = {16'd0, l[15:0]};
      end else begin
        rows = 1; rb = l;
      end
      ss = 32'(signed'(st[15:0]));
      ds = 32'(signed'(st[31:16]));
      for (int r = rows; r > 0; r--) begin
        b = rb;
        while (b != 0) begin
          if (inf[11]) dat = 0;
          else begin
            dat = mm[widx(s)];
            exp_rd.push_back(s);
          end
          if (!inf[7]) begin
            exp_wr.push_back('{addr: d, data: dat, len: l});
            mm[widx(d)] = dat;
          end
          if (inf[8]) s = s + 4;
          if (inf[4]) d = d + 4;
          b = b - 4;
          l = inf[1] ? {2'b00, 14'(r), b[15:0]} : b;
        end
        if (r > 1) begin
          s = s + ss;
          d = d + ds;
        end
      end
      exp_dn.push_back('{irq: inf[0], info: inf, src: s, dst: d, len: l,
                         nxt: mm[widx(ptr) + 5]});
      ptr = mm[widx(ptr) + 5];
      n++;
    end
  endtask

  // memory responder and on-the-fly comparison with the model
  always @(negedge clk) begin
    cyc++;
    if (mem_ack) begin
      mem_ack = 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_ack = 1;
        cnt = 0;
        lat = cyc % 3;
        if (mem_we) begin
          if (exp_wr.size() == 0)
            check(0, "R8", "unexpected write addr", mem_addr, 32'hx);
          else begin
            wr_t e;
            e = exp_wr.pop_front();
            check(mem_addr == e.addr, "R9", "write addr", mem_addr, e.addr);
            check(mem_wdata == e.data, "R7", "write data", mem_wdata, e.data);
            check(len_o == e.len, "R10", "live length", len_o, e.len);
          end
          mem[widx(mem_addr)] = mem_wdata;
        end else begin
          if (exp_rd.size() == 0)
            check(0, "R2", "unexpected read addr", mem_addr, 32'hx);
          else begin
            logic [31:0] ea;
            ea = exp_rd.pop_front();
            check(mem_addr == ea, "R2", "read addr", mem_addr, ea);
          end
          mem_rdata = mem[widx(mem_addr)];
        end
      end else begin
        cnt++;
      end
    end
    if (done_o) begin
      if (exp_dn.size() == 0)
        check(0, "R3", "unexpected done, info", info_o, 32'hx);
      else begin
        dn_t e;
        e = exp_dn.pop_front();
        check(irq_o == e.irq, "R11", "irq", 32'(irq_o), 32'(e.irq));
        check(info_o == e.info && next_o == e.nxt, "R2", "info field", info_o, e.info);
        check(src_o == e.src, "R6", "final src", src_o, e.src);
        check(dst_o == e.dst, "R6", "final dst", dst_o, e.dst);
        check(len_o == e.len, "R10", "final len", len_o, e.len);
      end
    end
    if (cyc > 150000 && !finished) begin
      finished = 1;
      check(0, "R3", "watchdog expired at cycle", 32'(cyc), 32'd150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_case(input string req, input logic [31:0] head, input int max_desc,
                          input bit en_at_start, input bit drop_en, input bit busy_start);
    int waited;
    model_run(head, max_desc);
    chan_en = en_at_start;
    @(negedge clk);
    head_ptr = head; start = 1;
    @(negedge clk);
    start = 0;
    if (drop_en) begin
      @(negedge clk);
      chan_en = 0;
    end
    if (busy_start) begin
      repeat (3) @(negedge clk);
      head_ptr = 32'h140; start = 1;
      @(negedge clk);
      start = 0;
    end
    waited = 0;
    while (!idle_o && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    repeat (3) @(negedge clk);
    check(idle_o, req, "idle at end", 32'(idle_o), 32'd1);
    check(exp_wr.size() == 0, req, "writes left", 32'(exp_wr.size()), 0);
    check(exp_dn.size() == 0, req, "done pulses left", 32'(exp_dn.size()), 0);
    check(exp_rd.size() == 0, req, "reads left", 32'(exp_rd.size()), 0);
    chan_en = 1;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'(i) * 32'h01010101 + 32'h7;
    // linear chain to a 2D descriptor
    put_desc(32'h100, 32'h111, 32'h400, 32'h800, 32'd16, 32'h0, 32'h120);
    put_desc(32'h120, 32'h112, 32'h500, 32'h900, 32'h00030008, 32'h00200010, 32'h0);
    // negative strides
    put_desc(32'h140, 32'h113, 32'h5C0, 32'hA80, 32'h0002000C, 32'hFFC0FFE0, 32'h0);
    // read-suppress, write-suppress, fixed addresses
    put_desc(32'h160, 32'h811, 32'h400, 32'hB00, 32'd8, 32'h0, 32'h180);
    put_desc(32'h180, 32'h180, 32'h400, 32'hB80, 32'd12, 32'h0, 32'h1A0);
    put_desc(32'h1A0, 32'h001, 32'h440, 32'hBC0, 32'd12, 32'h0, 32'h0);
    // zero rows, zero-byte rows, zero linear length
    put_desc(32'h1C0, 32'h113, 32'h400, 32'hC00, 32'h00000008, 32'h00100010, 32'h1E0);
    put_desc(32'h1E0, 32'h112, 32'h400, 32'hC00, 32'h00030000, 32'h00100020, 32'h200);
    put_desc(32'h200, 32'h001, 32'h400, 32'hC00, 32'h0, 32'h0, 32'h0);

    repeat (3) @(negedge clk);
    check(idle_o == 1, "R1", "idle in reset", 32'(idle_o), 1);
    rst_n = 1;
    @(negedge clk);
    check(idle_o == 1 && mem_req == 0, "R1", "idle after reset", 32'({idle_o, mem_req}), 32'b10);
    check(done_o == 0 && irq_o == 0, "R1", "done/irq after reset", 32'({done_o, irq_o}), 0);

    run_case("R4", 32'h100, 99, 1, 0, 0);       // R4 R5 R9 R10 linear then 2D
    run_case("R6", 32'h140, 99, 1, 0, 0);       // R6 negative strides
    run_case("R7", 32'h160, 99, 1, 0, 0);       // R7 R8 R9 flags
    run_case("R13", 32'h1C0, 99, 1, 0, 0);      // R13 empty work
    run_case("R3", 32'h100, 1, 1, 1, 1);        // R3 enable drop and busy start
    run_case("R3", 32'h100, 0, 0, 0, 0);        // R3 disabled at start
    run_case("R3", 32'h0, 99, 1, 0, 0);         // R3 null head
    run_case("R12", 32'h120, 99, 1, 0, 0);      // R12 R5 varying latency

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule